// File: doc/BRIEF.md
# Fetch line extractor

This block sits at the front of an instruction fetch stage that serves several hardware threads. Each thread keeps a buffered copy of one instruction-cache line, together with the line's address, its own fetch PC and the PC that follows it. When the stage asks to fetch for a thread, the block first clears the offset bits of that thread's PC. If the result matches the buffered line, the block takes a contiguous group of 32-bit instruction words from the line and sends them to the decode queue. If it does not match, the block issues a line request instead.

Each emitted instruction receives a number from one global sequence counter. A branch prediction port outside the block supplies a predicted next PC for each instruction. The group stops at the first of three limits: the fetch width, the end of the line, or an instruction predicted taken.

Two conditions halt a thread until it is redirected. A translation fault reported with the fetch is turned into a single no-op that carries the fault. A dedicated quiesce instruction word ends the group. A redirect sets a thread's PC, clears any halt, and takes precedence over a fetch to the same thread in the same cycle.

Top module: `fetch_extract`

## Requirements
- R1: After reset, `outValid` and `reqValid` are low, every thread state is Running (code 0), every `threadPc` equals RESET_PC, and the sequence counter is 0.
- R2: A fetch for a Running thread without a fault compares the PC, with its low log2(LINE_BYTES) bits cleared, against that thread's buffered line address. On a match, a group is emitted on the next cycle and `reqValid` stays low. On a mismatch, or when no line is buffered, the next cycle shows `reqValid`=1 with `reqAddr` set to the aligned PC, `reqTid` set to the thread, and no group.
- R3: Slot 0 holds the line word at index PC[log2(LINE_BYTES)-1:2]. Slot i holds the word at that index plus i, with `outPc` equal to the PC (low two bits cleared) plus 4*i. Word k of a line sits at bits [32k+31:32k] of `fillData`.
- R4: A group ends at the first of these: FETCH_WIDTH slots, the last word of the line, or a word k with `bpTaken[k]`=1. The taken word itself is emitted. Valid bits are contiguous from slot 0.
- R5: The predicted target of a slot holding word k is `bpTarget[32k+31:32k]` when `bpTaken[k]` is set, and otherwise that slot's PC plus 4.
- R6: Emitted instructions carry consecutive sequence numbers from a single counter shared by all threads. The counter advances by the number of instructions emitted, including fault no-ops.
- R7: After a group, the thread's `threadPc` equals the predicted target of the last emitted slot, and `threadNpc` equals that value plus 4.
- R8: A fetch with `fetchFault`=1 emits exactly one slot. That slot holds NOP_WORD, has `outFault`=1, carries `fetchFaultCode` in `outFaultCode`, and has a predicted target of PC+4. The PC is left unchanged and the thread state becomes TrapPending (code 1).
- R9: A word equal to QUIESCE_WORD is emitted and ends the group. The thread state becomes QuiescePending (code 2), and the PC advances as in R7.
- R10: A fetch for a thread whose state is not Running produces no group and no request, and leaves its PC unchanged. A redirect returns the thread to Running.
- R11: When a redirect and a fetch target the same thread in the same cycle, the redirect wins. No group is emitted, no sequence number is used, `threadPc` becomes `redirPc`, and `threadNpc` becomes `redirPc`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | Load a line into a thread's buffer |
| fillTid | input | TID_W | Thread receiving the line |
| fillAddr | input | ADDR_W | Address of the line (offset bits ignored) |
| fillData | input | LINE_BYTES*8 | Line contents, word k at [32k+31:32k] |
| redirValid | input | 1 | Redirect a thread's PC |
| redirTid | input | TID_W | Thread being redirected |
| redirPc | input | ADDR_W | New PC |
| fetchGo | input | 1 | Fetch request this cycle |
| fetchTid | input | TID_W | Thread to fetch for |
| fetchFault | input | 1 | Translation fault for this fetch |
| fetchFaultCode | input | FC_W | Fault code to carry |
| bpTaken | input | LINE_BYTES/4 | Predicted-taken flag per line word |
| bpTarget | input | LINE_BYTES/4*ADDR_W | Predicted target per line word |
| outValid | output | FETCH_WIDTH | Per-slot valid of the group |
| outInst | output | FETCH_WIDTH*32 | Instruction word per slot |
| outPc | output | FETCH_WIDTH*ADDR_W | PC per slot |
| outSeq | output | FETCH_WIDTH*SEQ_W | Sequence number per slot |
| outPredTarg | output | FETCH_WIDTH*ADDR_W | Predicted next PC per slot |
| outFault | output | 1 | Slot 0 is a fault-carrying no-op |
| outFaultCode | output | FC_W | Fault code of that no-op |
| reqValid | output | 1 | Line request issued |
| reqTid | output | TID_W | Thread of the request |
| reqAddr | output | ADDR_W | Aligned line address requested |
| threadState | output | NUM_THREADS*2 | State of thread t at [2t+1:2t] |
| threadPc | output | NUM_THREADS*ADDR_W | Fetch PC per thread |
| threadNpc | output | NUM_THREADS*ADDR_W | Following PC per thread |

## Verification
Two of the block's functions can land in the same cycle: a redirect and a fetch for the same thread. The bench provokes this by raising `redirValid` and `fetchGo` together for a Running thread that has a buffered line. It then expects an empty group, the redirect value in `threadPc` and `threadNpc`, and a sequence counter that was not advanced. The counter check is made on the following fetch, whose slot 0 must carry the number the bench predicted before the collision. Several table-driven cases also make a predicted-taken branch coincide with the width limit or the end of the line.

// File: rtl/fetch_extract_pkg.sv
package fetch_extract_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_TRAP    = 2'd1,
    ST_QUIESCE = 2'd2
  } thrState_e;

  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic extract;   // emit a group from the buffered line
    logic fault;     // emit a fault-carrying no-op
    logic missReq;   // issue a line request
  } fetchStrobe_t;

endpackage

// File: rtl/fetch_extract_ctrl.sv
module fetch_extract_ctrl
  import fetch_extract_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetchGo,
  input  logic [TID_W-1:0]         fetchTid,
  input  logic                     fetchFault,
  input  logic                     redirValid,
  input  logic [TID_W-1:0]         redirTid,
  input  logic                     lineHit,
  input  logic                     quiesceHit,
  output fetchStrobe_t             strobe,
  output logic [NUM_THREADS*2-1:0] threadState
);

  thrState_e stReg [NUM_THREADS];
  thrState_e curState;
  logic      goOk;

  always_comb begin
    curState = ST_RUN;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (fetchTid == TID_W'(t)) curState = stReg[t];
    end
  end

  assign goOk = fetchGo && (curState == ST_RUN) &&
                !(redirValid && (redirTid == fetchTid));

  always_comb begin
    strobe.fault   = goOk && fetchFault;
    strobe.extract = goOk && !fetchFault && lineHit;
    strobe.missReq = goOk && !fetchFault && !lineHit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_THREADS; t++) stReg[t] <= ST_RUN;
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (redirValid && (redirTid == TID_W'(t))) begin
          stReg[t] <= ST_RUN;
        end else if (fetchTid == TID_W'(t)) begin
          if (strobe.fault)                       stReg[t] <= ST_TRAP;
          else if (strobe.extract && quiesceHit)  stReg[t] <= ST_QUIESCE;
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_state
    assign threadState[t*2 +: 2] = stReg[t];
  end

endmodule

// File: rtl/fetch_extract_dpath.sv
module fetch_extract_dpath
  import fetch_extract_pkg::*;
#(
  parameter int          NUM_THREADS  = 2,
  parameter int          ADDR_W       = 32,
  parameter int          LINE_BYTES   = 32,
  parameter int          FETCH_WIDTH  = 4,
  parameter int          SEQ_W        = 16,
  parameter int          FC_W         = 4,
  parameter int          TID_W        = 1,
  parameter logic [31:0] NOP_WORD     = 32'h0000_0013,
  parameter logic [31:0] QUIESCE_WORD = 32'hFEED_0001,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  fetchStrobe_t                    strobe,
  input  logic [TID_W-1:0]                fetchTid,
  input  logic [FC_W-1:0]                 fetchFaultCode,
  input  logic                            redirValid,
  input  logic [TID_W-1:0]                redirTid,
  input  logic [ADDR_W-1:0]               redirPc,
  input  logic                            fillValid,
  input  logic [TID_W-1:0]                fillTid,
  input  logic [ADDR_W-1:0]               fillAddr,
  input  logic [LINE_BYTES*8-1:0]         fillData,
  input  logic [LINE_BYTES/4-1:0]         bpTaken,
  input  logic [LINE_BYTES/4*ADDR_W-1:0]  bpTarget,
  output logic                            lineHit,
  output logic                            quiesceHit,
  output logic [FETCH_WIDTH-1:0]          outValid,
  output logic [FETCH_WIDTH*32-1:0]       outInst,
  output logic [FETCH_WIDTH*ADDR_W-1:0]   outPc,
  output logic [FETCH_WIDTH*SEQ_W-1:0]    outSeq,
  output logic [FETCH_WIDTH*ADDR_W-1:0]   outPredTarg,
  output logic                            outFault,
  output logic [FC_W-1:0]                 outFaultCode,
  output logic                            reqValid,
  output logic [TID_W-1:0]                reqTid,
  output logic [ADDR_W-1:0]               reqAddr,
  output logic [NUM_THREADS*ADDR_W-1:0]   threadPc,
  output logic [NUM_THREADS*ADDR_W-1:0]   threadNpc
);

  localparam int WORDS     = LINE_BYTES / 4;
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = OFF_W - 2;
  localparam int SPAN_W    = IDX_W + $clog2(FETCH_WIDTH) + 1;
  localparam int CNT_W     = $clog2(FETCH_WIDTH + 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  // Per-thread state
  logic [LINE_BITS-1:0] lineData [NUM_THREADS];
  logic [ADDR_W-1:0]    lineTag  [NUM_THREADS];
  logic                 lineVld  [NUM_THREADS];
  logic [ADDR_W-1:0]    pcReg    [NUM_THREADS];
  logic [ADDR_W-1:0]    npcReg   [NUM_THREADS];
  logic [SEQ_W-1:0]     seqCtr;

  // Selected thread
  logic [ADDR_W-1:0]    curPc, curTag, alignedPc, basePc;
  logic [LINE_BITS-1:0] curLine;
  logic                 curVld;
  logic [IDX_W-1:0]     startIdx;

  // Group build
  logic [31:0]          slotWord [FETCH_WIDTH];
  logic [ADDR_W-1:0]    slotPc   [FETCH_WIDTH];
  logic [ADDR_W-1:0]    slotNext [FETCH_WIDTH];
  logic [FETCH_WIDTH-1:0] slotOk;
  logic [CNT_W-1:0]     grpCnt;
  logic [ADDR_W-1:0]    lastNext;

  always_comb begin
    curPc   = '0;
    curTag  = '0;
    curVld  = 1'b0;
    curLine = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (fetchTid == TID_W'(t)) begin
        curPc   = pcReg[t];
        curTag  = lineTag[t];
        curVld  = lineVld[t];
        curLine = lineData[t];
      end
    end
  end

  assign alignedPc = curPc & ~LINE_MASK;
  assign basePc    = {curPc[ADDR_W-1:2], 2'b00};
  assign startIdx  = curPc[OFF_W-1:2];
  assign lineHit   = curVld && (curTag == alignedPc);

  always_comb begin
    logic             stop;
    logic [SPAN_W-1:0] span;
    logic [IDX_W-1:0]  wIdx;
    logic              taken;
    logic              isQuiesce;
    stop       = 1'b0;
    quiesceHit = 1'b0;
    grpCnt     = '0;
    lastNext   = curPc;
    for (int i = 0; i < FETCH_WIDTH; i++) begin
      span        = SPAN_W'(startIdx) + SPAN_W'(i);
      wIdx        = span[IDX_W-1:0];
      slotWord[i] = curLine[32*int'(wIdx) +: 32];
      slotPc[i]   = basePc + ADDR_W'(4 * i);
      taken       = bpTaken[wIdx];
      isQuiesce   = (slotWord[i] == QUIESCE_WORD);
      slotNext[i] = taken ? bpTarget[ADDR_W*int'(wIdx) +: ADDR_W]
                          : slotPc[i] + ADDR_W'(4);
      slotOk[i]   = (span < SPAN_W'(WORDS)) && !stop;
      if (slotOk[i]) begin
        lastNext = slotNext[i];
        grpCnt   = grpCnt + CNT_W'(1);
        if (isQuiesce)         quiesceHit = 1'b1;
        if (taken || isQuiesce) stop      = 1'b1;
      end
    end
  end

  // Group and request registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid     <= '0;
      outInst      <= '0;
      outPc        <= '0;
      outSeq       <= '0;
      outPredTarg  <= '0;
      outFault     <= 1'b0;
      outFaultCode <= '0;
      reqValid     <= 1'b0;
      reqTid       <= '0;
      reqAddr      <= '0;
      seqCtr       <= '0;
    end else begin
      reqValid     <= strobe.missReq;
      reqTid       <= fetchTid;
      reqAddr      <= alignedPc;
      outFault     <= strobe.fault;
      outFaultCode <= strobe.fault ? fetchFaultCode : '0;
      if (strobe.extract) begin
        outValid <= slotOk;
        seqCtr   <= seqCtr + SEQ_W'(grpCnt);
        for (int i = 0; i < FETCH_WIDTH; i++) begin
          outInst[i*32 +: 32]         <= slotOk[i] ? slotWord[i] : '0;
          outPc[i*ADDR_W +: ADDR_W]   <= slotOk[i] ? slotPc[i]   : '0;
          outSeq[i*SEQ_W +: SEQ_W]    <= slotOk[i] ? seqCtr + SEQ_W'(i) : '0;
          outPredTarg[i*ADDR_W +: ADDR_W] <= slotOk[i] ? slotNext[i] : '0;
        end
      end else if (strobe.fault) begin
        outValid    <= FETCH_WIDTH'(1);
        seqCtr      <= seqCtr + SEQ_W'(1);
        outInst     <= '0;
        outPc       <= '0;
        outSeq      <= '0;
        outPredTarg <= '0;
        outInst[31:0]            <= NOP_WORD;
        outPc[ADDR_W-1:0]        <= curPc;
        outSeq[SEQ_W-1:0]        <= seqCtr;
        outPredTarg[ADDR_W-1:0]  <= curPc + ADDR_W'(4);
      end else begin
        outValid <= '0;
      end
    end
  end

  // Per-thread line buffers and PCs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        lineData[t] <= '0;
        lineTag[t]  <= '0;
        lineVld[t]  <= 1'b0;
        pcReg[t]    <= RESET_PC;
        npcReg[t]   <= RESET_PC + ADDR_W'(4);
      end
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (fillValid && (fillTid == TID_W'(t))) begin
          lineData[t] <= fillData;
          lineTag[t]  <= fillAddr & ~LINE_MASK;
          lineVld[t]  <= 1'b1;
        end
        if (redirValid && (redirTid == TID_W'(t))) begin
          pcReg[t]  <= redirPc;
          npcReg[t] <= redirPc + ADDR_W'(4);
        end else if (strobe.extract && (fetchTid == TID_W'(t))) begin
          pcReg[t]  <= lastNext;
          npcReg[t] <= lastNext + ADDR_W'(4);
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pc
    assign threadPc[t*ADDR_W +: ADDR_W]  = pcReg[t];
    assign threadNpc[t*ADDR_W +: ADDR_W] = npcReg[t];
  end

endmodule

// File: rtl/fetch_extract.sv
module fetch_extract
  import fetch_extract_pkg::*;
#(
  parameter int          NUM_THREADS  = 2,
  parameter int          ADDR_W       = 32,
  parameter int          LINE_BYTES   = 32,
  parameter int          FETCH_WIDTH  = 4,
  parameter int          SEQ_W        = 16,
  parameter int          FC_W         = 4,
  parameter logic [31:0] NOP_WORD     = 32'h0000_0013,
  parameter logic [31:0] QUIESCE_WORD = 32'hFEED_0001,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int WORDS = LINE_BYTES / 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fillValid,
  input  logic [TID_W-1:0]                fillTid,
  input  logic [ADDR_W-1:0]               fillAddr,
  input  logic [LINE_BYTES*8-1:0]         fillData,
  input  logic                            redirValid,
  input  logic [TID_W-1:0]                redirTid,
  input  logic [ADDR_W-1:0]               redirPc,
  input  logic                            fetchGo,
  input  logic [TID_W-1:0]                fetchTid,
  input  logic                            fetchFault,
  input  logic [FC_W-1:0]                 fetchFaultCode,
  input  logic [WORDS-1:0]                bpTaken,
  input  logic [WORDS*ADDR_W-1:0]         bpTarget,
  output logic [FETCH_WIDTH-1:0]          outValid,
  output logic [FETCH_WIDTH*32-1:0]       outInst,
  output logic [FETCH_WIDTH*ADDR_W-1:0]   outPc,
  output logic [FETCH_WIDTH*SEQ_W-1:0]    outSeq,
  output logic [FETCH_WIDTH*ADDR_W-1:0]   outPredTarg,
  output logic                            outFault,
  output logic [FC_W-1:0]                 outFaultCode,
  output logic                            reqValid,
  output logic [TID_W-1:0]                reqTid,
  output logic [ADDR_W-1:0]               reqAddr,
  output logic [NUM_THREADS*2-1:0]        threadState,
  output logic [NUM_THREADS*ADDR_W-1:0]   threadPc,
  output logic [NUM_THREADS*ADDR_W-1:0]   threadNpc
);

  fetchStrobe_t strobe;
  logic         lineHit;
  logic         quiesceHit;

  fetch_extract_ctrl #(
    .NUM_THREADS(NUM_THREADS),
    .TID_W      (TID_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchGo    (fetchGo),
    .fetchTid   (fetchTid),
    .fetchFault (fetchFault),
    .redirValid (redirValid),
    .redirTid   (redirTid),
    .lineHit    (lineHit),
    .quiesceHit (quiesceHit),
    .strobe     (strobe),
    .threadState(threadState)
  );

  fetch_extract_dpath #(
    .NUM_THREADS (NUM_THREADS),
    .ADDR_W      (ADDR_W),
    .LINE_BYTES  (LINE_BYTES),
    .FETCH_WIDTH (FETCH_WIDTH),
    .SEQ_W       (SEQ_W),
    .FC_W        (FC_W),
    .TID_W       (TID_W),
    .NOP_WORD    (NOP_WORD),
    .QUIESCE_WORD(QUIESCE_WORD),
    .RESET_PC    (RESET_PC)
  ) u_dpath (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .fetchTid      (fetchTid),
    .fetchFaultCode(fetchFaultCode),
    .redirValid    (redirValid),
    .redirTid      (redirTid),
    .redirPc       (redirPc),
    .fillValid     (fillValid),
    .fillTid       (fillTid),
    .fillAddr      (fillAddr),
    .fillData      (fillData),
    .bpTaken       (bpTaken),
    .bpTarget      (bpTarget),
    .lineHit       (lineHit),
    .quiesceHit    (quiesceHit),
    .outValid      (outValid),
    .outInst       (outInst),
    .outPc         (outPc),
    .outSeq        (outSeq),
    .outPredTarg   (outPredTarg),
    .outFault      (outFault),
    .outFaultCode  (outFaultCode),
    .reqValid      (reqValid),
    .reqTid        (reqTid),
    .reqAddr       (reqAddr),
    .threadPc      (threadPc),
    .threadNpc     (threadNpc)
  );

endmodule

// File: rtl/fetch_extract_chk.sv
module fetch_extract_chk #(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int FETCH_WIDTH = 4,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          fetchGo,
  input logic [TID_W-1:0]              fetchTid,
  input logic                          redirValid,
  input logic [TID_W-1:0]              redirTid,
  input logic [FETCH_WIDTH-1:0]        outValid,
  input logic [FETCH_WIDTH*SEQ_W-1:0]  outSeq,
  input logic                          outFault,
  input logic                          reqValid,
  input logic [ADDR_W-1:0]             reqAddr,
  input logic [NUM_THREADS*2-1:0]      threadState
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [1:0] selState;
  logic       haltedGo;

  always_comb begin
    selState = 2'd0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (fetchTid == TID_W'(t)) selState = threadState[t*2 +: 2];
    end
  end

  assign haltedGo = fetchGo && (selState != 2'd0) &&
                    !(redirValid && (redirTid == fetchTid));

  // R4
  contig_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid & (outValid + FETCH_WIDTH'(1))) == '0);

  // R8
  fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outFault |-> (outValid == FETCH_WIDTH'(1)));

  // R2
  miss_no_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (outValid == '0));

  // R2
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (reqAddr[OFF_W-1:0] == '0));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    haltedGo |=> ((outValid == '0) && !reqValid));

  for (genvar i = 1; i < FETCH_WIDTH; i++) begin : g_seq
    // R6
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      outValid[i] |-> (outSeq[i*SEQ_W +: SEQ_W] ==
                       outSeq[(i-1)*SEQ_W +: SEQ_W] + SEQ_W'(1)));
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_st
    // R1
    state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      threadState[t*2 +: 2] != 2'd3);
  end

endmodule

bind fetch_extract fetch_extract_chk #(
  .NUM_THREADS(NUM_THREADS),
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .FETCH_WIDTH(FETCH_WIDTH),
  .SEQ_W      (SEQ_W),
  .TID_W      (TID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetchGo    (fetchGo),
  .fetchTid   (fetchTid),
  .redirValid (redirValid),
  .redirTid   (redirTid),
  .outValid   (outValid),
  .outSeq     (outSeq),
  .outFault   (outFault),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .threadState(threadState)
);

// File: tb/fetch_extract_bench.sv
`timescale 1ns/1ps
module fetch_extract_bench;

  localparam int NT = 2;
  localparam int AW = 32;
  localparam int LB = 32;
  localparam int FW = 4;
  localparam int SW = 16;
  localparam int FCW = 4;
  localparam int NW = LB / 4;
  localparam logic [31:0] NOP_W = 32'h0000_0013;
  localparam logic [31:0] QUI_W = 32'hFEED_0001;

  // {start word[45:43], taken mask[42:35], count[34:32], final next PC[31:0]}
  localparam logic [45:0] VEC [7] = '{
    {3'd0, 8'h00, 3'd4, 32'h0000_1010},
    {3'd6, 8'h00, 3'd2, 32'h0000_1020},
    {3'd1, 8'h04, 3'd2, 32'h0000_4200},
    {3'd0, 8'h01, 3'd1, 32'h0000_4000},
    {3'd4, 8'h80, 3'd4, 32'h0000_4700},
    {3'd7, 8'h00, 3'd1, 32'h0000_1020},
    {3'd3, 8'h40, 3'd4, 32'h0000_4600}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fillValid = 1'b0;
  logic [0:0] fillTid = '0;
  logic [AW-1:0] fillAddr = '0;
  logic [LB*8-1:0] fillData = '0;
  logic redirValid = 1'b0;
  logic [0:0] redirTid = '0;
  logic [AW-1:0] redirPc = '0;
  logic fetchGo = 1'b0;
  logic [0:0] fetchTid = '0;
  logic fetchFault = 1'b0;
  logic [FCW-1:0] fetchFaultCode = '0;
  logic [NW-1:0] bpTaken = '0;
  logic [NW*AW-1:0] bpTarget;
  logic [FW-1:0] outValid;
  logic [FW*32-1:0] outInst;
  logic [FW*AW-1:0] outPc;
  logic [FW*SW-1:0] outSeq;
  logic [FW*AW-1:0] outPredTarg;
  logic outFault;
  logic [FCW-1:0] outFaultCode;
  logic reqValid;
  logic [0:0] reqTid;
  logic [AW-1:0] reqAddr;
  logic [NT*2-1:0] threadState;
  logic [NT*AW-1:0] threadPc;
  logic [NT*AW-1:0] threadNpc;

  int total = 0;
  int bad = 0;
  int expSeq = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_extract u_fetch_extract (
    .clk(clk), .rst_n(rst_n),
    .fillValid(fillValid), .fillTid(fillTid), .fillAddr(fillAddr), .fillData(fillData),
    .redirValid(redirValid), .redirTid(redirTid), .redirPc(redirPc),
    .fetchGo(fetchGo), .fetchTid(fetchTid), .fetchFault(fetchFault),
    .fetchFaultCode(fetchFaultCode), .bpTaken(bpTaken), .bpTarget(bpTarget),
    .outValid(outValid), .outInst(outInst), .outPc(outPc), .outSeq(outSeq),
    .outPredTarg(outPredTarg), .outFault(outFault), .outFaultCode(outFaultCode),
    .reqValid(reqValid), .reqTid(reqTid), .reqAddr(reqAddr),
    .threadState(threadState), .threadPc(threadPc), .threadNpc(threadNpc)
  );

  always_comb begin
    for (int k = 0; k < NW; k++) bpTarget[k*AW +: AW] = 32'h4000 + 32'(k) * 32'h100;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic tid, input logic [AW-1:0] addr, input logic [LB*8-1:0] data);
    fillValid = 1'b1; fillTid = tid; fillAddr = addr; fillData = data;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doRedir(input logic tid, input logic [AW-1:0] pc);
    redirValid = 1'b1; redirTid = tid; redirPc = pc;
    @(negedge clk);
    redirValid = 1'b0;
  endtask

  task automatic doFetch(input logic tid, input logic flt, input logic [FCW-1:0] code);
    fetchGo = 1'b1; fetchTid = tid; fetchFault = flt; fetchFaultCode = code;
    @(negedge clk);
    fetchGo = 1'b0; fetchFault = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [LB*8-1:0] line0, line1;
    for (int k = 0; k < NW; k++) begin
      line0[k*32 +: 32] = 32'hA000_0000 + 32'(k);
      line1[k*32 +: 32] = (k == 3) ? QUI_W : 32'hB000_0000 + 32'(k);
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outValid", 64'(outValid), 0);
    chk("R1 reqValid", 64'(reqValid), 0);
    chk("R1 threadState", 64'(threadState), 0);
    chk("R1 threadPc", 64'(threadPc), 0);

    // R2 miss with no buffered line
    doFetch(1'b0, 1'b0, '0);
    chk("R2 miss reqValid", 64'(reqValid), 1);
    chk("R2 miss reqAddr", 64'(reqAddr), 0);
    chk("R2 miss no group", 64'(outValid), 0);

    doFill(1'b0, 32'h1000, line0);

    // Table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < 7; v++) begin
      logic [2:0] st;
      logic [7:0] msk;
      logic [2:0] cnt;
      logic [31:0] nxt;
      {st, msk, cnt, nxt} = VEC[v];
      bpTaken = msk;
      doRedir(1'b0, 32'h1000 + 32'(st) * 4);
      doFetch(1'b0, 1'b0, '0);
      chk("R4 group valid", 64'(outValid), 64'((1 << cnt) - 1));
      chk("R2 hit no request", 64'(reqValid), 0);
      chk("R3 slot0 pc", 64'(outPc[AW-1:0]), 64'(32'h1000 + 32'(st) * 4));
      chk("R3 slot0 word", 64'(outInst[31:0]), 64'(32'hA000_0000 + 32'(st)));
      chk("R6 slot0 seq", 64'(outSeq[SW-1:0]), 64'(expSeq));
      chk("R5 last target", 64'(outPredTarg[(int'(cnt) - 1) * AW +: AW]), 64'(nxt));
      chk("R7 threadPc", 64'(threadPc[AW-1:0]), 64'(nxt));
      chk("R7 threadNpc", 64'(threadNpc[AW-1:0]), 64'(nxt + 4));
      expSeq += int'(cnt);
    end
    bpTaken = '0;

    // R2 alignment of a mid-line PC on another thread
    doRedir(1'b1, 32'h2008);
    doFetch(1'b1, 1'b0, '0);
    chk("R2 aligned reqAddr", 64'(reqAddr), 64'h2000);
    chk("R2 reqTid", 64'(reqTid), 1);
    doFill(1'b1, 32'h2000, line1);

    // R9 quiesce ends group
    doFetch(1'b1, 1'b0, '0);
    chk("R9 group to quiesce", 64'(outValid), 64'h3);
    chk("R9 quiesce word", 64'(outInst[63:32]), 64'(QUI_W));
    chk("R6 shared seq", 64'(outSeq[SW-1:0]), 64'(expSeq));
    chk("R9 state", 64'(threadState[3:2]), 2);
    chk("R9 pc advance", 64'(threadPc[2*AW-1:AW]), 64'h2010);
    expSeq += 2;

    // R10 halted thread ignores fetch
    doFetch(1'b1, 1'b0, '0);
    chk("R10 no group", 64'(outValid), 0);
    chk("R10 no request", 64'(reqValid), 0);
    chk("R10 pc held", 64'(threadPc[2*AW-1:AW]), 64'h2010);
    doRedir(1'b1, 32'h2000);
    chk("R10 redirect runs", 64'(threadState[3:2]), 0);

    // R8 fault no-op
    doRedir(1'b0, 32'h1004);
    doFetch(1'b0, 1'b1, 4'h5);
    chk("R8 single slot", 64'(outValid), 1);
    chk("R8 fault flag", 64'(outFault), 1);
    chk("R8 fault code", 64'(outFaultCode), 5);
    chk("R8 nop word", 64'(outInst[31:0]), 64'(NOP_W));
    chk("R8 target", 64'(outPredTarg[AW-1:0]), 64'h1008);
    chk("R8 seq", 64'(outSeq[SW-1:0]), 64'(expSeq));
    chk("R8 state", 64'(threadState[1:0]), 1);
    chk("R8 pc held", 64'(threadPc[AW-1:0]), 64'h1004);
    expSeq += 1;
    doFetch(1'b0, 1'b0, '0);
    chk("R10 trap ignores fetch", 64'(outValid), 0);

    // R11 redirect and fetch to the same thread in one cycle
    doRedir(1'b0, 32'h1000);
    redirValid = 1'b1; redirTid = 1'b0; redirPc = 32'h1018;
    fetchGo = 1'b1; fetchTid = 1'b0;
    @(negedge clk);
    redirValid = 1'b0; fetchGo = 1'b0;
    chk("R11 no group", 64'(outValid), 0);
    chk("R11 pc", 64'(threadPc[AW-1:0]), 64'h1018);
    chk("R11 npc", 64'(threadNpc[AW-1:0]), 64'h101C);
    doFetch(1'b0, 1'b0, '0);
    chk("R11 seq unused", 64'(outSeq[SW-1:0]), 64'(expSeq));
    chk("R4 line end", 64'(outValid), 64'h3);
    expSeq += 2;

    // R6 counter shared across threads, R9 at the width limit
    doFetch(1'b1, 1'b0, '0);
    chk("R6 tid1 seq", 64'(outSeq[SW-1:0]), 64'(expSeq));
    chk("R9 quiesce in last slot", 64'(outValid), 64'hF);
    chk("R9 state again", 64'(threadState[3:2]), 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule